// File: doc/BRIEF.md
# Banked 24-bit address generator

This block turns the operand of a 16-bit processor core into a 24-bit bus address. Memory is seen by the core as sixteen 64 KB banks. Each bank is named by a 4-bit extension field. There is one field for extended addressing, one for each of the three index registers and one for the stack pointer. A mode select chooses how the 20-bit linear address is formed:

- **Extended mode:** the linear address is the extension field joined to a 16-bit operand.
- **Indexed and stack modes:** a bank-plus-register base plus a signed 16-bit displacement, computed across the bank boundary.
- **Vector mode:** an exception vector fetch address in bank 0.

The top four address bits always copy bit 19. This folds the upper half of the 20-bit space onto the top of the 24-bit map and leaves a hole in the middle.

The extension fields are loaded from the low nibble of an 8-bit accumulator when a write strobe and a field select are given. The result is registered. An address presented with a mode code appears on the output one clock later. A field write on an edge first affects the address computed for the following cycle.

Top module: `bank_addr_gen`

## Requirements
- R1: Mode code 0 (extended) gives bits 19:16 equal to the extended field and bits 15:0 equal to `offset_i`. The address appears on `addr_o` one clock after the mode is presented.
- R2: Mode codes 1, 2 and 3 (indexed by `ix_i`, `iy_i`, `iz_i`) add the sign-extended `offset_i` to {index field, index register} modulo 2^20. A carry or borrow out of bit 15 changes the bank bits.
- R3: Mode code 4 (stack) forms the address the same way from {stack field, `sp_i`} plus the sign-extended `offset_i`.
- R4: `addr_o[23:20]` always equals `addr_o[19]`, so no address from 0x080000 to 0xF7FFFF ever appears.
- R5: Mode code 5 (vector) gives twice `vec_i` with the bank bits zero. Vector 255 yields 0x0001FE.
- R6: On a clock edge with `bk_wr_i` high, the field chosen by `bk_sel_i` loads `acc_b_i[3:0]`. The select codes are 0 extended, 1 X, 2 Y, 3 Z and 4 stack. The new value is used for addresses presented after that edge.
- R7: `acc_b_i[7:4]` never reaches a field. A select code of 5, 6 or 7 changes no field.
- R8: Reset clears every extension field and drives `addr_o` to 0.
- R9: Mode codes 6 and 7 hold `addr_o` at its previous value.
- R10: With the Y field 0xA, `iy_i` 0 and a displacement of 0x7300 in mode 2, `addr_o` is 0xFA7300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Address mode code |
| offset_i | input | 16 | Extended operand or signed displacement |
| ix_i | input | 16 | Index register X |
| iy_i | input | 16 | Index register Y |
| iz_i | input | 16 | Index register Z |
| sp_i | input | 16 | Stack pointer |
| vec_i | input | 8 | Exception vector number |
| bk_wr_i | input | 1 | Extension field write strobe |
| bk_sel_i | input | 3 | Extension field select |
| acc_b_i | input | 8 | Accumulator B, low nibble is the write data |
| addr_o | output | 24 | Registered bus address |

## Verification
The bound checker watches the following relations on every cycle:
- the mirrored upper nibble and the resulting gap in the map;
- the extended-mode offset bits;
- the exact vector fetch address;
- the held output for unused mode codes.

Only the bench's scenarios can show the rest, because it depends on the contents of the extension fields:
- bank carry and borrow in indexed and stack modes;
- which field a write lands in;
- that the accumulator's high nibble and unused select codes are dropped;
- the write-then-use ordering.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_EXT   = 3'd0,
        MODE_IDX_X = 3'd1,
        MODE_IDX_Y = 3'd2,
        MODE_IDX_Z = 3'd3,
        MODE_STACK = 3'd4,
        MODE_VEC   = 3'd5
    } addr_mode_e;

    // field slots inside the extension file, equal to the write select codes
    localparam int FLD_EXT = 0;
    localparam int FLD_X   = 1;
    localparam int FLD_Y   = 2;
    localparam int FLD_Z   = 3;
    localparam int FLD_SP  = 4;
    localparam int NUM_FLD = 5;

endpackage

// File: rtl/bank_addr_ext_file.sv
module bank_addr_ext_file
    import bank_addr_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int SEL_W  = 3,
    parameter int ACC_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [SEL_W-1:0]                  sel_i,
    input  logic [ACC_W-1:0]                  acc_i,
    output logic [NUM_FLD-1:0][BANK_W-1:0]    fld_o
);

    typedef struct packed {
        logic [NUM_FLD-1:0][BANK_W-1:0] fld;
    } ext_state_t;

    ext_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int i = 0; i < NUM_FLD; i++) begin
                if (sel_i == SEL_W'(i)) begin
                    st_d.fld[i] = acc_i[BANK_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fld_o = st_q.fld;

endmodule

// File: rtl/bank_addr_calc.sv
module bank_addr_calc
    import bank_addr_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int OFS_W  = 16,
    parameter int VEC_W  = 8,
    localparam int LIN_W = BANK_W + OFS_W
) (
    input  logic [MODE_W-1:0]              mode_i,
    input  logic [OFS_W-1:0]               offset_i,
    input  logic [OFS_W-1:0]               ix_i,
    input  logic [OFS_W-1:0]               iy_i,
    input  logic [OFS_W-1:0]               iz_i,
    input  logic [OFS_W-1:0]               sp_i,
    input  logic [VEC_W-1:0]               vec_i,
    input  logic [NUM_FLD-1:0][BANK_W-1:0] fld_i,
    output logic [LIN_W-1:0]               lin_o,
    output logic                           valid_o
);

    logic [BANK_W-1:0] base_bank;
    logic [OFS_W-1:0]  base_reg;
    logic [LIN_W-1:0]  disp_ext;
    logic [LIN_W-1:0]  rel_sum;
    logic [LIN_W-1:0]  vec_addr;

    // base selection for the register-relative modes
    always_comb begin
        base_bank = fld_i[FLD_X];
        base_reg  = ix_i;
        case (mode_i)
            MODE_IDX_Y: begin
                base_bank = fld_i[FLD_Y];
                base_reg  = iy_i;
            end
            MODE_IDX_Z: begin
                base_bank = fld_i[FLD_Z];
                base_reg  = iz_i;
            end
            MODE_STACK: begin
                base_bank = fld_i[FLD_SP];
                base_reg  = sp_i;
            end
            default: begin
                base_bank = fld_i[FLD_X];
                base_reg  = ix_i;
            end
        endcase
    end

    // a full-width adder lets carries and borrows run into the bank bits
    assign disp_ext = {{BANK_W{offset_i[OFS_W-1]}}, offset_i};
    assign rel_sum  = {base_bank, base_reg} + disp_ext;
    assign vec_addr = LIN_W'({vec_i, 1'b0});

    always_comb begin
        lin_o   = '0;
        valid_o = 1'b1;
        case (mode_i)
            MODE_EXT:   lin_o = {fld_i[FLD_EXT], offset_i};
            MODE_IDX_X,
            MODE_IDX_Y,
            MODE_IDX_Z,
            MODE_STACK: lin_o = rel_sum;
            MODE_VEC:   lin_o = vec_addr;
            default:    valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bank_addr_mirror.sv
module bank_addr_mirror #(
    parameter int LIN_W = 20,
    parameter int HI_W  = 4,
    localparam int BUS_W = LIN_W + HI_W
) (
    input  logic [LIN_W-1:0] lin_i,
    output logic [BUS_W-1:0] bus_o
);

    assign bus_o[LIN_W-1:0] = lin_i;

    for (genvar g = 0; g < HI_W; g++) begin : g_hi
        assign bus_o[LIN_W+g] = lin_i[LIN_W-1];
    end

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bank_addr_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int OFS_W  = 16,
    parameter int HI_W   = 4,
    parameter int VEC_W  = 8,
    parameter int SEL_W  = 3,
    parameter int ACC_W  = 8,
    localparam int LIN_W = BANK_W + OFS_W,
    localparam int BUS_W = LIN_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [OFS_W-1:0]  ix_i,
    input  logic [OFS_W-1:0]  iy_i,
    input  logic [OFS_W-1:0]  iz_i,
    input  logic [OFS_W-1:0]  sp_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              bk_wr_i,
    input  logic [SEL_W-1:0]  bk_sel_i,
    input  logic [ACC_W-1:0]  acc_b_i,
    output logic [BUS_W-1:0]  addr_o
);

    typedef struct packed {
        logic [BUS_W-1:0] addr;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [NUM_FLD-1:0][BANK_W-1:0] fld;
    logic [LIN_W-1:0]               lin;
    logic                           lin_valid;
    logic [BUS_W-1:0]               bus;

    bank_addr_ext_file #(
        .BANK_W (BANK_W),
        .SEL_W  (SEL_W),
        .ACC_W  (ACC_W)
    ) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (bk_wr_i),
        .sel_i   (bk_sel_i),
        .acc_i   (acc_b_i),
        .fld_o   (fld)
    );

    bank_addr_calc #(
        .BANK_W (BANK_W),
        .OFS_W  (OFS_W),
        .VEC_W  (VEC_W)
    ) u_calc (
        .mode_i   (mode_i),
        .offset_i (offset_i),
        .ix_i     (ix_i),
        .iy_i     (iy_i),
        .iz_i     (iz_i),
        .sp_i     (sp_i),
        .vec_i    (vec_i),
        .fld_i    (fld),
        .lin_o    (lin),
        .valid_o  (lin_valid)
    );

    bank_addr_mirror #(
        .LIN_W (LIN_W),
        .HI_W  (HI_W)
    ) u_mirror (
        .lin_i (lin),
        .bus_o (bus)
    );

    always_comb begin
        st_d = st_q;
        if (lin_valid) begin
            st_d.addr = bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk
    import bank_addr_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int OFS_W  = 16,
    parameter int HI_W   = 4,
    parameter int VEC_W  = 8,
    localparam int LIN_W = BANK_W + OFS_W,
    localparam int BUS_W = LIN_W + HI_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic [OFS_W-1:0]  offset_i,
    input logic [VEC_W-1:0]  vec_i,
    input logic [BUS_W-1:0]  addr_o
);

    localparam logic [BUS_W-1:0] GAP_LO = BUS_W'(1) << (LIN_W - 1);
    localparam logic [BUS_W-1:0] GAP_HI = ~((BUS_W'(1) << (LIN_W - 1)) - BUS_W'(1));

    p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[BUS_W-1:LIN_W] == {HI_W{addr_o[LIN_W-1]}});

    p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o < GAP_LO) || (addr_o >= GAP_HI));

    p_ext_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_EXT) |=> (addr_o[OFS_W-1:0] == $past(offset_i)));

    p_vec_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_VEC) |=> (addr_o == BUS_W'({$past(vec_i), 1'b0})));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i > MODE_VEC) |=> $stable(addr_o));

endmodule

bind bank_addr_gen bank_addr_gen_chk #(
    .BANK_W (BANK_W),
    .OFS_W  (OFS_W),
    .HI_W   (HI_W),
    .VEC_W  (VEC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .offset_i (offset_i),
    .vec_i    (vec_i),
    .addr_o   (addr_o)
);

// File: tb/bank_addr_gen_bench.sv
`timescale 1ns/1ps
module bank_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] ofs = '0, ix = '0, iy = '0, iz = '0, sp = '0;
    logic [7:0]  vec = '0;
    logic        wr = 1'b0;
    logic [2:0]  sel = '0;
    logic [7:0]  accb = '0;
    logic [23:0] addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0]  mdl_fld [5];
    logic [23:0] mdl_addr = '0;

    always #4 clk = ~clk;

    bank_addr_gen u_bank_addr_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .offset_i(ofs),
        .ix_i(ix), .iy_i(iy), .iz_i(iz), .sp_i(sp), .vec_i(vec),
        .bk_wr_i(wr), .bk_sel_i(sel), .acc_b_i(accb), .addr_o(addr)
    );

    function automatic logic [23:0] expect_addr();
        logic [19:0] lin;
        logic [19:0] dsx;
        dsx = {{4{ofs[15]}}, ofs};
        case (mode)
            3'd0: lin = {mdl_fld[0], ofs};
            3'd1: lin = {mdl_fld[1], ix} + dsx;
            3'd2: lin = {mdl_fld[2], iy} + dsx;
            3'd3: lin = {mdl_fld[3], iz} + dsx;
            3'd4: lin = {mdl_fld[4], sp} + dsx;
            3'd5: lin = {11'd0, vec, 1'b0};
            default: return mdl_addr;
        endcase
        return {{4{lin[19]}}, lin};
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1, 3'd2, 3'd3: return "R2";
            3'd4: return "R3";
            3'd5: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_o=%06h expected %06h", tag, act, exp);
        end
    endtask

    // inputs are already set; called at a negedge
    task automatic apply(input string tag);
        logic [23:0] e;
        e = expect_addr();
        if (wr && sel < 3'd5) mdl_fld[sel] = accb[3:0];
        mdl_addr = e;
        @(posedge clk);
        @(negedge clk);
        check(tag, addr, e);
        // R4 mirror of bit 19 on every vector
        check("R4", {20'd0, addr[23:20]}, {20'd0, {4{addr[19]}}});
        wr = 1'b0;
    endtask

    task automatic write_fld(input logic [2:0] s, input logic [7:0] b, input string tag);
        wr = 1'b1; sel = s; accb = b; mode = 3'd6;
        apply(tag);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        for (int i = 0; i < 5; i++) mdl_fld[i] = 4'h0;
        repeat (3) @(negedge clk);
        check("R8", addr, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: fields cleared, extended and indexed use bank 0
        mode = 3'd0; ofs = 16'h1234; apply("R8");
        mode = 3'd1; ix = 16'h0100; ofs = 16'h0010; apply("R8");

        // R10 worked example
        write_fld(3'd2, 8'h0A, "R6");
        mode = 3'd2; iy = 16'h0000; ofs = 16'h7300; apply("R10");
        check("R10", addr, 24'hFA7300);

        // R2 carry into bank, R2 borrow out of bank 0 wraps to 0xFFFFFF
        write_fld(3'd1, 8'h03, "R6");
        mode = 3'd1; ix = 16'hFFF0; ofs = 16'h0020; apply("R2");
        check("R2", addr, 24'h040010);
        write_fld(3'd3, 8'h00, "R6");
        mode = 3'd3; iz = 16'h0000; ofs = 16'hFFFF; apply("R2");
        check("R4", addr, 24'hFFFFFF);

        // R3 stack borrow across bank
        write_fld(3'd4, 8'h07, "R6");
        mode = 3'd4; sp = 16'h0004; ofs = 16'hFFF0; apply("R3");
        check("R3", addr, 24'h06FFF4);

        // R7 high nibble ignored, unused select codes write nothing
        write_fld(3'd0, 8'hF5, "R7");
        mode = 3'd0; ofs = 16'h0000; apply("R7");
        check("R7", addr, 24'h050000);
        write_fld(3'd5, 8'h0C, "R7");
        write_fld(3'd7, 8'h0C, "R7");
        mode = 3'd0; ofs = 16'hABCD; apply("R7");
        check("R7", addr, 24'h05ABCD);

        // R6 write on the same edge as an address: old field used, new after
        mode = 3'd0; ofs = 16'h0001; wr = 1'b1; sel = 3'd0; accb = 8'h08; apply("R6");
        check("R6", addr, 24'h050001);
        mode = 3'd0; ofs = 16'h0001; apply("R6");
        check("R6", addr, 24'hF80001);

        // R5 vector extremes
        mode = 3'd5; vec = 8'hFF; apply("R5");
        check("R5", addr, 24'h0001FE);
        mode = 3'd5; vec = 8'h00; apply("R5");
        // R9 hold
        mode = 3'd7; ofs = 16'h5555; apply("R9");
        check("R9", addr, 24'h000000);

        for (int k = 0; k < 3000; k++) begin
            mode = 3'($urandom % 8);
            ofs  = 16'($urandom);
            ix   = 16'($urandom);
            iy   = 16'($urandom);
            iz   = 16'($urandom);
            sp   = 16'($urandom);
            vec  = 8'($urandom);
            wr   = ($urandom % 4) == 0;
            sel  = 3'($urandom % 8);
            accb = 8'($urandom);
            apply(tag_of(mode));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule